// File: doc/BRIEF.md
# Descriptor-Driven DMA Command Engine

This block runs one DMA channel from a list of 16-byte descriptors held in memory. When software has set the channel going, the engine reads the descriptor at its command pointer and decodes the operation. An operation is one of four things. It can be a stream transfer in either direction, handed to the peripheral through a request/done handshake. It can be a single-word store to, or load from, a register space. It can be a no-op. Or it can be a halt. Once a command finishes, the engine writes the remaining byte count and a status word back into the descriptor. It then either steps to the next descriptor or jumps to a branch target taken from the descriptor.

Every descriptor carries three independent 2-bit condition codes: one for interrupt, one for branch and one for wait. Each code is tested against a condition bit. That bit is formed from the peripheral's 8-bit status, a mask byte and a match byte. Some commands have illegal combinations of address and key. Such a command puts the channel into a dead state, with no write-back.

Descriptor layout in memory, as 32-bit little-endian words at the pointer:
- word 0 holds the requested byte count in bits 15:0 and the command in bits 31:16;
- word 1 holds the data address;
- word 2 holds the command-dependent value;
- word 3 holds the residual count in bits 15:0 and the status in bits 31:16.

Top module: `desc_cmd_engine`

## Requirements
- R1: The engine reads descriptor words 0, 1 and 2 at pointer+0, +4 and +8, in that order. Word 0 bits 15:0 are the byte count, and word 0 bits 31:16 are the command. Word 1 is the data address, and word 2 is the dependent value.
- R2: Command bits 15:12 give the operation: 0 output, 1 output with end mark, 2 input, 3 input with end mark, 4 store word, 5 load word, 6 no-op. Codes 7 to 15 halt. Command bits 10:8 are the key.
- R3: Command bits 5:4, 3:2 and 1:0 are the interrupt, branch and wait codes. Each code selects a condition: 0 never, 1 when the condition bit is 1, 2 when it is 0, 3 always. The condition bit is 1 when (dev_stat & sel[15:8]) equals (sel[7:0] & sel[15:8]), where sel is the matching selector input.
- R4: After write-back, a firing branch loads the dependent value into the pointer. Otherwise the pointer advances by 16.
- R5: A firing interrupt code sets irq_o. irq_o stays set until irq_ack_i is pulsed.
- R6: While the wait code fires, the finished command is held. The channel stays active, and neither write-back nor a pointer change occurs. When the wait condition drops, the command completes.
- R7: Write-back stores one word at pointer+12. Bits 15:0 hold the residual count: the peripheral's residual for transfers and 0 otherwise. Bits 31:16 hold the status: bit 15 run, bit 11 dead, bit 10 active, bit 8 branch taken, bits 7:0 dev_stat.
- R8: An input command with data address 0 or key above 3 kills the channel. Output commands are never killed.
- R9: A store or load with key below 5 kills the channel. A store writes the dependent value to the data address. A load reads the data address and writes the result to pointer+8.
- R10: A kill clears active, sets dead and sets irq_o. It writes nothing back and leaves the pointer unchanged.
- R11: A fetch starts only with run_i high, active set and dead clear. start_i sets active and clears dead. A halt clears active, leaving the pointer and the descriptor unchanged.
- R12: A pointer write is ignored while the channel is active.
- R13: mem_req_o holds its address and direction until mem_ack_i arrives. xfer_req_o holds until xfer_done_i arrives. The two requests are never high together.
- R14: A transfer request drives the following fields: direction (1 for output), end mark (operation bit 0), key, data address and byte count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_i | input | 1 | Run enable |
| start_i | input | 1 | Pulse: set active, clear dead |
| ptr_we_i | input | 1 | Command pointer write strobe |
| ptr_wdata_i | input | 32 | Command pointer write value |
| intr_sel_i | input | 16 | Interrupt condition mask/match |
| br_sel_i | input | 16 | Branch condition mask/match |
| wait_sel_i | input | 16 | Wait condition mask/match |
| dev_stat_i | input | 8 | Peripheral status bits |
| irq_ack_i | input | 1 | Clears irq_o |
| active_o | output | 1 | Channel active |
| dead_o | output | 1 | Channel killed |
| irq_o | output | 1 | Interrupt request level |
| cmd_ptr_o | output | 32 | Command pointer |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory access is a write |
| mem_addr_o | output | 32 | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data, valid with ack |
| mem_ack_i | input | 1 | Memory access complete |
| xfer_req_o | output | 1 | Stream transfer request |
| xfer_out_o | output | 1 | 1 memory-to-stream, 0 stream-to-memory |
| xfer_last_o | output | 1 | End mark for this transfer |
| xfer_key_o | output | 3 | Stream key |
| xfer_addr_o | output | 32 | Data address |
| xfer_len_o | output | 16 | Requested byte count |
| xfer_done_i | input | 1 | Transfer complete |
| xfer_resid_i | input | 16 | Bytes left, valid with done |

## Verification
The assertions run on every cycle and check three things:
- both handshakes hold steady while they wait, and the two request ports never overlap;
- a kill leaves the channel inactive, interrupting and silent on both ports;
- the pointer changes only through a write while the channel is idle or at a completed memory write.

Several behaviours can only be shown by the bench's scenarios, because they depend on memory contents seen from outside:
- the outcome of every branch and interrupt code under both condition values;
- the exact residual and status words written back;
- each kill rule, and the output command that escapes it;
- the wait hold and the run gate.

// File: rtl/desc_pkg.sv
package desc_pkg;

    localparam int DESC_BYTES   = 16;
    localparam int FETCH_WORDS  = 3;
    localparam int KEY_STRM_MAX = 3;
    localparam int KEY_REG_MIN  = 5;

    localparam int SB_RUN    = 15;
    localparam int SB_DEAD   = 11;
    localparam int SB_ACTIVE = 10;
    localparam int SB_BT     = 8;

    typedef enum logic [1:0] {
        CC_NEVER  = 2'd0,
        CC_IFSET  = 2'd1,
        CC_IFCLR  = 2'd2,
        CC_ALWAYS = 2'd3
    } cc_e;

    typedef struct packed {
        logic [3:0] op;
        logic [2:0] key;
        cc_e        ic;
        cc_e        bc;
        cc_e        wc;
    } cmd_t;

    typedef enum logic [2:0] {
        ACT_XFER, ACT_REG, ACT_NOP, ACT_HALT, ACT_KILL
    } act_e;

    typedef struct packed {
        act_e act;
        logic out;
        logic last;
        logic load;
    } dec_t;

    typedef enum logic [2:0] {
        S_IDLE, S_FETCH, S_DECODE, S_XFER, S_REG, S_LDWB, S_COND, S_WB
    } st_e;

    function automatic logic cc_apply(cc_e code, logic c);
        case (code)
            CC_NEVER:  return 1'b0;
            CC_IFSET:  return c;
            CC_IFCLR:  return !c;
            default:   return 1'b1;
        endcase
    endfunction

endpackage

// File: rtl/dde_cond.sv
module dde_cond
    import desc_pkg::*;
#(
    parameter int STAT_W = 8
) (
    input  logic [2*STAT_W-1:0] sel_i,
    input  logic [STAT_W-1:0]   stat_i,
    input  cc_e                 code_i,
    output logic                fire_o
);
    logic [STAT_W-1:0] mask;
    logic [STAT_W-1:0] match;
    logic              cbit;

    assign mask   = sel_i[2*STAT_W-1:STAT_W];
    assign match  = sel_i[STAT_W-1:0];
    assign cbit   = ((stat_i & mask) == (match & mask));
    assign fire_o = cc_apply(code_i, cbit);
endmodule

// File: rtl/dde_decode.sv
module dde_decode
    import desc_pkg::*;
(
    input  cmd_t        cmd_i,
    input  logic [31:0] addr_i,
    output dec_t        dec_o
);
    always_comb begin
        dec_o.act  = ACT_HALT;
        dec_o.out  = 1'b0;
        dec_o.last = cmd_i.op[0];
        dec_o.load = cmd_i.op[0];
        case (cmd_i.op)
            4'd0, 4'd1: begin
                dec_o.act = ACT_XFER;
                dec_o.out = 1'b1;
            end
            4'd2, 4'd3: begin
                if (addr_i == 32'd0 || 32'(cmd_i.key) > KEY_STRM_MAX)
                    dec_o.act = ACT_KILL;
                else
                    dec_o.act = ACT_XFER;
            end
            4'd4, 4'd5: begin
                if (32'(cmd_i.key) < KEY_REG_MIN)
                    dec_o.act = ACT_KILL;
                else
                    dec_o.act = ACT_REG;
            end
            4'd6:    dec_o.act = ACT_NOP;
            default: dec_o.act = ACT_HALT;
        endcase
    end
endmodule

// File: rtl/desc_cmd_engine.sv
module desc_cmd_engine
    import desc_pkg::*;
#(
    parameter int STAT_W = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                run_i,
    input  logic                start_i,
    input  logic                ptr_we_i,
    input  logic [31:0]         ptr_wdata_i,
    input  logic [2*STAT_W-1:0] intr_sel_i,
    input  logic [2*STAT_W-1:0] br_sel_i,
    input  logic [2*STAT_W-1:0] wait_sel_i,
    input  logic [STAT_W-1:0]   dev_stat_i,
    input  logic                irq_ack_i,
    output logic                active_o,
    output logic                dead_o,
    output logic                irq_o,
    output logic [31:0]         cmd_ptr_o,
    output logic                mem_req_o,
    output logic                mem_we_o,
    output logic [31:0]         mem_addr_o,
    output logic [31:0]         mem_wdata_o,
    input  logic [31:0]         mem_rdata_i,
    input  logic                mem_ack_i,
    output logic                xfer_req_o,
    output logic                xfer_out_o,
    output logic                xfer_last_o,
    output logic [2:0]          xfer_key_o,
    output logic [31:0]         xfer_addr_o,
    output logic [15:0]         xfer_len_o,
    input  logic                xfer_done_i,
    input  logic [15:0]         xfer_resid_i
);
    localparam int NCOND = 3;

    st_e         state;
    logic [1:0]  fidx;
    logic [31:0] ptr, phy_q, dep_q;
    logic [15:0] len_q, resid_q;
    cmd_t        cmd_q;
    logic        active_q, dead_q, irq_q;
    dec_t        dec;
    logic [NCOND-1:0]               fire;
    logic [NCOND-1:0][2*STAT_W-1:0] sels;
    cc_e         codes [NCOND];
    logic [15:0] status_w;

    dde_decode u_dec (.cmd_i(cmd_q), .addr_i(phy_q), .dec_o(dec));

    assign sels[0]  = intr_sel_i;
    assign sels[1]  = br_sel_i;
    assign sels[2]  = wait_sel_i;
    assign codes[0] = cmd_q.ic;
    assign codes[1] = cmd_q.bc;
    assign codes[2] = cmd_q.wc;

    for (genvar gi = 0; gi < NCOND; gi++) begin : g_cond
        dde_cond #(.STAT_W(STAT_W)) u_cond (
            .sel_i (sels[gi]),
            .stat_i(dev_stat_i),
            .code_i(codes[gi]),
            .fire_o(fire[gi])
        );
    end

    always_comb begin
        status_w            = '0;
        status_w[SB_RUN]    = run_i;
        status_w[SB_DEAD]   = dead_q;
        status_w[SB_ACTIVE] = active_q;
        status_w[SB_BT]     = fire[1];
        status_w[STAT_W-1:0] = dev_stat_i;
    end

    always_comb begin
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = ptr;
        mem_wdata_o = dep_q;
        case (state)
            S_FETCH: begin
                mem_req_o  = 1'b1;
                mem_addr_o = ptr + {28'd0, fidx, 2'b00};
            end
            S_REG: begin
                mem_req_o  = 1'b1;
                mem_we_o   = !dec.load;
                mem_addr_o = phy_q;
            end
            S_LDWB: begin
                mem_req_o  = 1'b1;
                mem_we_o   = 1'b1;
                mem_addr_o = ptr + 32'd8;
            end
            S_WB: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = ptr + 32'd12;
                mem_wdata_o = {status_w, resid_q};
            end
            default: ;
        endcase
    end

    assign xfer_req_o  = (state == S_XFER);
    assign xfer_out_o  = dec.out;
    assign xfer_last_o = dec.last;
    assign xfer_key_o  = cmd_q.key;
    assign xfer_addr_o = phy_q;
    assign xfer_len_o  = len_q;

    assign active_o  = active_q;
    assign dead_o    = dead_q;
    assign irq_o     = irq_q;
    assign cmd_ptr_o = ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            fidx     <= '0;
            ptr      <= '0;
            phy_q    <= '0;
            dep_q    <= '0;
            len_q    <= '0;
            resid_q  <= '0;
            cmd_q    <= '0;
            active_q <= 1'b0;
            dead_q   <= 1'b0;
            irq_q    <= 1'b0;
        end else begin
            if (irq_ack_i) irq_q <= 1'b0;
            if (start_i) begin
                active_q <= 1'b1;
                dead_q   <= 1'b0;
            end
            if (ptr_we_i && !active_q) ptr <= ptr_wdata_i;
            case (state)
                S_IDLE: begin
                    fidx <= '0;
                    if (run_i && active_q && !dead_q) state <= S_FETCH;
                end
                S_FETCH: if (mem_ack_i) begin
                    case (fidx)
                        2'd0: begin
                            len_q <= mem_rdata_i[15:0];
                            cmd_q <= '{op:  mem_rdata_i[31:28],
                                       key: mem_rdata_i[26:24],
                                       ic:  cc_e'(mem_rdata_i[21:20]),
                                       bc:  cc_e'(mem_rdata_i[19:18]),
                                       wc:  cc_e'(mem_rdata_i[17:16])};
                        end
                        2'd1:    phy_q <= mem_rdata_i;
                        default: dep_q <= mem_rdata_i;
                    endcase
                    fidx <= fidx + 2'd1;
                    if (32'(fidx) == FETCH_WORDS - 1) state <= S_DECODE;
                end
                S_DECODE: begin
                    resid_q <= '0;
                    case (dec.act)
                        ACT_XFER: state <= S_XFER;
                        ACT_REG:  state <= S_REG;
                        ACT_NOP:  state <= S_COND;
                        ACT_KILL: begin
                            active_q <= 1'b0;
                            dead_q   <= 1'b1;
                            irq_q    <= 1'b1;
                            state    <= S_IDLE;
                        end
                        default: begin
                            active_q <= 1'b0;
                            state    <= S_IDLE;
                        end
                    endcase
                end
                S_XFER: if (xfer_done_i) begin
                    resid_q <= xfer_resid_i;
                    state   <= S_COND;
                end
                S_REG: if (mem_ack_i) begin
                    if (dec.load) begin
                        dep_q <= mem_rdata_i;
                        state <= S_LDWB;
                    end else begin
                        state <= S_COND;
                    end
                end
                S_LDWB: if (mem_ack_i) state <= S_COND;
                S_COND: if (!fire[2]) state <= S_WB;
                S_WB: if (mem_ack_i) begin
                    if (fire[0]) irq_q <= 1'b1;
                    ptr   <= fire[1] ? dep_q : ptr + 32'(DESC_BYTES);
                    state <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/desc_cmd_engine_chk.sv
module desc_cmd_engine_chk (
    input logic        clk,
    input logic        rst,
    input logic        active_o,
    input logic        dead_o,
    input logic        irq_o,
    input logic [31:0] cmd_ptr_o,
    input logic        ptr_we_i,
    input logic        mem_req_o,
    input logic        mem_we_o,
    input logic [31:0] mem_addr_o,
    input logic        mem_ack_i,
    input logic        xfer_req_o,
    input logic        xfer_done_i
);
    p_mem_hold_r13: assert property (@(posedge clk) disable iff (rst)
        mem_req_o && !mem_ack_i |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));

    p_xfer_hold_r13: assert property (@(posedge clk) disable iff (rst)
        xfer_req_o && !xfer_done_i |=> xfer_req_o);

    p_one_port_r13: assert property (@(posedge clk) disable iff (rst)
        !(mem_req_o && xfer_req_o));

    p_kill_effect_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(dead_o) |-> !active_o && irq_o);

    p_dead_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        dead_o |-> !mem_req_o && !xfer_req_o);

    p_xfer_needs_active_r11: assert property (@(posedge clk) disable iff (rst)
        xfer_req_o |-> active_o);

    p_ptr_source_r12: assert property (@(posedge clk) disable iff (rst)
        !$stable(cmd_ptr_o) |-> $past(ptr_we_i && !active_o) || $past(mem_ack_i && mem_we_o));
endmodule

bind desc_cmd_engine desc_cmd_engine_chk u_chk (.*);

// File: tb/desc_cmd_engine_bench.sv
`timescale 1ns/1ps
module desc_cmd_engine_bench;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst = 1'b1, run = 1'b1, start = 1'b0, ptr_we = 1'b0, irq_ack = 1'b0;
    logic [31:0] ptr_wdata = '0;
    logic [15:0] intr_sel = '0, br_sel = '0, wait_sel = '0;
    logic [7:0]  dev = '0;
    logic        active, dead, irq;
    logic [31:0] cmd_ptr;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        xreq, xout, xlast, xdone;
    logic [2:0]  xkey;
    logic [31:0] xaddr;
    logic [15:0] xlen, xresid;

    logic [31:0] mem [0:63];
    int nchk = 0, nfail = 0;
    bit done_flag = 0;

    logic [1:0]  xcnt;
    logic        cap_out, cap_last;
    logic [2:0]  cap_key;
    logic [31:0] cap_addr;
    logic [15:0] cap_len;

    desc_cmd_engine u_desc_cmd_engine (
        .clk(clk), .rst(rst), .run_i(run), .start_i(start),
        .ptr_we_i(ptr_we), .ptr_wdata_i(ptr_wdata),
        .intr_sel_i(intr_sel), .br_sel_i(br_sel), .wait_sel_i(wait_sel),
        .dev_stat_i(dev), .irq_ack_i(irq_ack),
        .active_o(active), .dead_o(dead), .irq_o(irq), .cmd_ptr_o(cmd_ptr),
        .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_ack_i(mem_ack),
        .xfer_req_o(xreq), .xfer_out_o(xout), .xfer_last_o(xlast),
        .xfer_key_o(xkey), .xfer_addr_o(xaddr), .xfer_len_o(xlen),
        .xfer_done_i(xdone), .xfer_resid_i(xresid)
    );

    always @(posedge clk) begin
        if (rst) begin
            mem_ack   <= 1'b0;
            mem_rdata <= '0;
        end else begin
            mem_ack <= mem_req && !mem_ack;
            if (mem_req && !mem_ack) begin
                mem_rdata <= mem[mem_addr[7:2]];
                if (mem_we) mem[mem_addr[7:2]] = mem_wdata;
            end
        end
    end

    always @(posedge clk) begin
        if (rst) begin
            xcnt   <= '0;
            xdone  <= 1'b0;
            xresid <= '0;
        end else begin
            xdone <= 1'b0;
            if (xreq && !xdone) begin
                cap_out  <= xout;
                cap_last <= xlast;
                cap_key  <= xkey;
                cap_addr <= xaddr;
                cap_len  <= xlen;
                if (xcnt == 2'd2) begin
                    xdone  <= 1'b1;
                    xresid <= xlen >> 2;
                    xcnt   <= '0;
                end else begin
                    xcnt <= xcnt + 2'd1;
                end
            end
        end
    end

    function automatic logic [31:0] dw0(input int op, input int key, input int ic,
                                        input int bc, input int wc, input int len);
        logic [15:0] c;
        c = {op[3:0], 1'b0, key[2:0], 2'b00, ic[1:0], bc[1:0], wc[1:0]};
        return {c, len[15:0]};
    endfunction

    localparam logic [31:0] HALT_W = 32'h7000_0000;
    localparam logic [31:0] SENT   = 32'hDEAD_BEEF;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic clear_mem();
        for (int i = 0; i < 64; i++) mem[i] = '0;
        mem[3]  = SENT;
        mem[4]  = HALT_W;
        mem[32] = HALT_W;
    endtask

    task automatic set_ptr(input logic [31:0] p);
        @(negedge clk); ptr_we = 1'b1; ptr_wdata = p;
        @(negedge clk); ptr_we = 1'b0;
    endtask

    task automatic kick();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (active && n < 500) begin
            @(negedge clk); n++;
        end
        if (active) begin
            nfail++;
            $display("FAIL R11 channel never went idle actual 1 expected 0");
        end
    endtask

    task automatic run_from(input logic [31:0] p);
        set_ptr(p); kick(); wait_idle();
    endtask

    task automatic ack_irq();
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 150000);
        nfail++;
        $display("FAIL watchdog expired actual hung expected finished");
        finish_run();
    end

    initial begin
        clear_mem();
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state
        check("R11 reset active", 32'(active), 0);
        check("R10 reset dead", 32'(dead), 0);
        check("R5 reset irq", 32'(irq), 0);
        check("R4 reset ptr", cmd_ptr, 0);
        check("R13 reset reqs", {30'd0, mem_req, xreq}, 0);

        // R4 / R3 / R7 / R1: branch code sweep over both condition values
        br_sel = 16'h0101;
        for (int b = 0; b < 4; b++) begin
            for (int c = 0; c < 2; c++) begin
                logic taken;
                clear_mem();
                mem[0] = dw0(6, 0, 0, b, 0, 0);
                mem[2] = 32'h80;
                dev = 8'(c);
                taken = (b == 3) || (b == 1 && c == 1) || (b == 2 && c == 0);
                run_from(0);
                check("R4 branch ptr", cmd_ptr, taken ? 32'h80 : 32'h10);
                check("R7 nop writeback", mem[3],
                      {16'h8400 | (taken ? 16'h0100 : 16'h0) | 16'(c), 16'h0});
            end
        end
        br_sel = '0;

        // R5 / R3: interrupt code sweep
        intr_sel = 16'h0303;
        for (int ic = 0; ic < 4; ic++) begin
            for (int c = 0; c < 2; c++) begin
                logic fires;
                clear_mem();
                mem[0] = dw0(6, 0, ic, 0, 0, 0);
                dev = (c == 1) ? 8'h07 : 8'h05;
                fires = (ic == 3) || (ic == 1 && c == 1) || (ic == 2 && c == 0);
                run_from(0);
                check("R5 interrupt code", 32'(irq), 32'(fires));
                check("R4 no branch ptr", cmd_ptr, 32'h10);
                ack_irq();
                check("R5 irq ack clears", 32'(irq), 0);
            end
        end
        intr_sel = '0;

        // R14 / R7: output transfer
        clear_mem();
        mem[0] = dw0(0, 0, 0, 0, 0, 40);
        mem[1] = 32'h100;
        dev = 8'h5A;
        run_from(0);
        check("R14 out dir", 32'(cap_out), 1);
        check("R14 out last", 32'(cap_last), 0);
        check("R14 out key", 32'(cap_key), 0);
        check("R14 out addr", cap_addr, 32'h100);
        check("R14 out len", 32'(cap_len), 40);
        check("R7 out writeback", mem[3], {16'h845A, 16'd10});
        check("R4 out ptr", cmd_ptr, 32'h10);

        // R14 / R2: input with end mark on stream 3
        clear_mem();
        mem[0] = dw0(3, 3, 0, 0, 0, 100);
        mem[1] = 32'h200;
        dev = 8'h00;
        run_from(0);
        check("R14 in dir", 32'(cap_out), 0);
        check("R14 in last", 32'(cap_last), 1);
        check("R14 in key", 32'(cap_key), 3);
        check("R7 in writeback", mem[3], {16'h8400, 16'd25});
        check("R8 legal input not dead", 32'(dead), 0);

        // R8: output with zero address and key 4 is not killed
        clear_mem();
        mem[0] = dw0(1, 4, 0, 0, 0, 8);
        run_from(0);
        check("R8 output never killed", 32'(dead), 0);
        check("R14 key 4 passed", 32'(cap_key), 4);
        check("R8 output ptr", cmd_ptr, 32'h10);

        // R8 / R10: input with zero address
        clear_mem();
        mem[0] = dw0(2, 0, 0, 0, 0, 8);
        run_from(0);
        check("R10 kill dead", 32'(dead), 1);
        check("R10 kill irq", 32'(irq), 1);
        check("R10 kill ptr", cmd_ptr, 0);
        check("R10 kill no writeback", mem[3], SENT);
        ack_irq();

        // R8: input with key above 3
        clear_mem();
        mem[0] = dw0(2, 4, 0, 0, 0, 8);
        mem[1] = 32'h100;
        run_from(0);
        check("R8 input key 4 kills", 32'(dead), 1);
        ack_irq();

        // R9: store with key below 5
        clear_mem();
        mem[0] = dw0(4, 2, 0, 0, 0, 4);
        mem[1] = 32'h40;
        run_from(0);
        check("R9 store key 2 kills", 32'(dead), 1);
        check("R9 killed store no write", mem[16], 0);
        ack_irq();

        // R9: legal store
        clear_mem();
        mem[0] = dw0(4, 5, 0, 0, 0, 4);
        mem[1] = 32'h40;
        mem[2] = 32'hCAFE_F00D;
        dev = 8'h11;
        run_from(0);
        check("R9 store data", mem[16], 32'hCAFE_F00D);
        check("R9 store not dead", 32'(dead), 0);
        check("R7 store writeback", mem[3], {16'h8411, 16'h0});

        // R9: legal load
        clear_mem();
        mem[0]  = dw0(5, 6, 0, 0, 0, 4);
        mem[1]  = 32'h44;
        mem[17] = 32'h1234_5678;
        dev = 8'h00;
        run_from(0);
        check("R9 load into descriptor", mem[2], 32'h1234_5678);
        check("R9 load ptr", cmd_ptr, 32'h10);

        // R6 / R12: wait hold, pointer write ignored while active
        clear_mem();
        mem[0] = dw0(6, 0, 0, 0, 1, 0);
        wait_sel = 16'h0101;
        dev = 8'h01;
        set_ptr(0);
        kick();
        repeat (30) @(negedge clk);
        check("R6 still active while waiting", 32'(active), 1);
        check("R6 no writeback while waiting", mem[3], SENT);
        set_ptr(32'h200);
        check("R12 ptr write ignored", cmd_ptr, 0);
        dev = 8'h00;
        wait_idle();
        check("R6 resumes ptr", cmd_ptr, 32'h10);
        check("R6 resumes writeback", mem[3], {16'h8400, 16'h0});
        wait_sel = '0;

        // R11: run low gates fetch
        clear_mem();
        mem[0] = dw0(6, 0, 0, 0, 0, 0);
        run = 1'b0;
        set_ptr(0);
        kick();
        repeat (20) @(negedge clk);
        check("R11 run low active held", 32'(active), 1);
        check("R11 run low no writeback", mem[3], SENT);
        run = 1'b1;
        wait_idle();
        check("R11 run high proceeds", cmd_ptr, 32'h10);

        // R11 / R2: halt and undefined operation
        for (int op = 7; op < 10; op += 2) begin
            clear_mem();
            mem[0] = dw0(op, 0, 3, 3, 0, 0);
            run_from(0);
            check("R11 halt inactive", 32'(active), 0);
            check("R11 halt ptr", cmd_ptr, 0);
            check("R11 halt no writeback", mem[3], SENT);
            check("R2 halt not dead", 32'(dead), 0);
            check("R2 halt no irq", 32'(irq), 0);
        end

        finish_run();
    end
endmodule